// File: doc/BRIEF.md
# Serial Frame Transmitter with In-Place Parity

This block turns one data word into an asynchronous serial frame. The frame begins with a low start bit and ends with a high stop bit, and the line sits high between frames. A width select picks an 8-bit or a 9-bit data field. A parity enable keeps the frame the same length but replaces the top bit of that field with a computed even or odd parity bit. Every bit stays on the line for sixteen pulses of an oversampling tick that the surrounding logic supplies at sixteen times the bit rate.

The user presents a word and its mode on the inputs and pulses `load` for one clock. The word is taken only while the transmitter is idle. `busy` stays high for the whole frame. A one-clock `done` pulse marks the end of the stop bit, and a new word may be loaded in that same cycle.

Top module: `uart_par_tx`

## Requirements
- R1: After reset, and for as long as no frame is being sent, `txd` is 1 and `busy` and `done` are 0. Ticks arriving while idle do not change the line.
- R2: A `load` seen while idle is accepted on that clock edge. From the next cycle `busy` is 1 and `txd` carries the start bit, which is 0.
- R3: Each frame bit stays on `txd` for exactly 16 `tick_x16` pulses. The order is the start bit, then the data field from bit 0 (least significant) upward, then a stop bit of 1.
- R4: With `wide_sel`=0 and `par_en`=0 the frame is 10 bits: start, `data_in[7:0]`, stop.
- R5: With `wide_sel`=0 and `par_en`=1 the frame is 10 bits: start, `data_in[6:0]`, the parity bit in place of `data_in[7]`, stop.
- R6: With `wide_sel`=1 and `par_en`=0 the frame is 11 bits: start, `data_in[8:0]`, stop.
- R7: With `wide_sel`=1 and `par_en`=1 the frame is 11 bits: start, `data_in[7:0]`, the parity bit in place of `data_in[8]`, stop.
- R8: With `par_odd`=0 the parity bit makes the number of ones in the low data bits (7 narrow, 8 wide) plus the parity bit even. With `par_odd`=1 it makes that number odd. For data 0x35 in a narrow frame the parity bit is 0 under even parity and 1 under odd parity.
- R9: A `load` that arrives while `busy` is 1 is ignored. The frame in progress goes on unchanged. Later changes on `data_in` and on the mode inputs also have no effect on it.
- R10: On the 16th tick of the stop bit, `busy` falls and `done` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_x16 | input | 1 | Oversampling tick at 16 times the bit rate, one cycle wide |
| load | input | 1 | Request to start a frame with the presented word |
| data_in | input | 9 | Word to send, bit 0 sent first |
| wide_sel | input | 1 | 0: 8-bit data field, 1: 9-bit data field |
| par_en | input | 1 | 1: top bit of the field is replaced by parity |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse at the end of the stop bit |

## Verification
The hardest case to reach is a load request that lands in the middle of a frame, together with changes on the data and mode inputs, all of which must leave the frame on the line untouched. The stimulus reaches it by raising `load` with a different random word and mode partway through a data bit of selected frames, and on the same cycle as a tick. Random idle gaps are placed between ticks so that the 16-tick bit hold is checked against an irregular tick rhythm and not a fixed cycle count. Directed frames with the top data bit set check that parity overwrites that bit, and directed frames with data 0x35 pin the parity value under both settings.

// File: rtl/uart_par_tx_pkg.sv
package uart_par_tx_pkg;

    localparam int unsigned PAR_MAX_W = 16;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic wide;
        logic par_en;
        logic par_odd;
    } tx_mode_t;

    // Parity over the lowest n bits of vec, seeded with the odd flag.
    function automatic logic calc_parity(input logic [PAR_MAX_W-1:0] vec,
                                         input int unsigned n,
                                         input logic odd);
        logic acc;
        acc = odd;
        for (int unsigned i = 0; i < PAR_MAX_W; i++) begin
            if (i < n) acc = acc ^ vec[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/uart_par_tx_frame.sv
module uart_par_tx_frame
    import uart_par_tx_pkg::*;
#(
    parameter int unsigned DATA_W  = 9,
    parameter int unsigned FRAME_W = DATA_W + 2,
    parameter int unsigned IDX_W   = $clog2(FRAME_W)
) (
    input  logic [DATA_W-1:0]  data,
    input  tx_mode_t           mode,
    output logic [FRAME_W-1:0] frame,
    output logic [IDX_W-1:0]   last_idx
);

    localparam int unsigned PAD_W = PAR_MAX_W - DATA_W;

    int unsigned field_len;
    logic        par_bit;

    always_comb begin
        field_len = mode.wide ? DATA_W : DATA_W - 1;
        par_bit   = calc_parity({{PAD_W{1'b0}}, data}, field_len - 1, mode.par_odd);
        frame     = '1;
        frame[0]  = 1'b0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            if (i < field_len) frame[i+1] = data[i];
        end
        if (mode.par_en) frame[field_len] = par_bit;
        last_idx  = IDX_W'(field_len + 1);
    end

endmodule

// File: rtl/uart_par_tx_baud.sv
module uart_par_tx_baud #(
    parameter int unsigned OSR  = 16,
    parameter int unsigned CW   = $clog2(OSR)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic bit_end
);

    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    assign bit_end = run && tick && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
        end
    end

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt)); // R3

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |-> (cnt == '0)); // R3

endmodule

// File: rtl/uart_par_tx_shift.sv
module uart_par_tx_shift
    import uart_par_tx_pkg::*;
#(
    parameter int unsigned FRAME_W = 11,
    parameter int unsigned IDX_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [IDX_W-1:0]   last_in,
    input  logic               bit_end,
    output logic               txd,
    output logic               busy,
    output logic               done
);

    tx_state_e          state;
    logic [FRAME_W-1:0] sreg;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   last_q;

    assign busy = (state == TX_SEND);
    assign txd  = sreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            sreg   <= '1;
            idx    <= '0;
            last_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        sreg   <= frame_in;
                        idx    <= '0;
                        last_q <= last_in;
                        state  <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (bit_end) begin
                        if (idx == last_q) begin
                            state <= TX_IDLE;
                            sreg  <= '1;
                            done  <= 1'b1;
                        end else begin
                            sreg <= {1'b1, sreg[FRAME_W-1:1]};
                            idx  <= idx + 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd); // R1

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !txd)); // R2

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_end) |=> (busy && $stable(sreg))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R10

endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
    import uart_par_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_x16,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wide_sel,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned IDX_W   = $clog2(FRAME_W);

    tx_mode_t           mode;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   last_idx;
    logic               start;
    logic               bit_end;
    logic [FRAME_W-1:0] field_mask;

    assign mode  = '{wide: wide_sel, par_en: par_en, par_odd: par_odd};
    assign start = load && !busy;

    uart_par_tx_frame #(
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .IDX_W  (IDX_W)
    ) frame_i (
        .data    (data_in),
        .mode    (mode),
        .frame   (frame),
        .last_idx(last_idx)
    );

    uart_par_tx_baud #(
        .OSR(OSR)
    ) baud_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .run    (busy),
        .tick   (tick_x16),
        .bit_end(bit_end)
    );

    uart_par_tx_shift #(
        .FRAME_W(FRAME_W),
        .IDX_W  (IDX_W)
    ) shift_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame_in(frame),
        .last_in (last_idx),
        .bit_end (bit_end),
        .txd     (txd),
        .busy    (busy),
        .done    (done)
    );

    // Positions 1..field length hold the data field including parity.
    always_comb begin
        field_mask = '0;
        for (int unsigned i = 1; i <= DATA_W; i++) begin
            if (wide_sel || i < DATA_W) field_mask[i] = 1'b1;
        end
    end

    AST_PARITY_RULE: assert property (@(posedge clk) disable iff (rst)
        (start && par_en) |-> ((^(frame & field_mask)) == par_odd)); // R8

    AST_LOAD_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (load && busy) |=> busy || done); // R9

endmodule

// File: tb/uart_par_tx_tb_top.sv
module uart_par_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_x16 = 1'b0;
    logic       load = 1'b0;
    logic [8:0] data_in = '0;
    logic       wide_sel = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       txd, busy, done;

    int checks = 0;
    int failures = 0;
    logic [10:0] cap;

    always #2 clk = ~clk;

    uart_par_tx dut_i (
        .clk(clk), .rst(rst), .tick_x16(tick_x16), .load(load),
        .data_in(data_in), .wide_sel(wide_sel), .par_en(par_en),
        .par_odd(par_odd), .txd(txd), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [8:0] d, input logic w,
                                              input logic pe, input logic po,
                                              output int nbits);
        logic [10:0] f;
        int fl;
        logic p;
        fl = w ? 9 : 8;
        p  = po;
        for (int i = 0; i < fl - 1; i++) p = p ^ d[i];
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < fl; i++) f[i+1] = d[i];
        if (pe) f[fl] = p;
        nbits = fl + 2;
        return f;
    endfunction

    task automatic one_tick(input bit gaps);
        tick_x16 = 1'b1;
        @(negedge clk);
        tick_x16 = 1'b0;
        if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input logic w, input logic pe,
                              input logic po, input bit inject);
        logic [10:0] ef;
        int nb;
        string tag;
        ef = exp_frame(d, w, pe, po, nb);
        tag = inject ? "R9" : (w ? (pe ? "R7" : "R6") : (pe ? "R5" : "R4"));
        cap = '1;
        @(negedge clk);
        data_in = d; wide_sel = w; par_en = pe; par_odd = po; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        data_in = 9'($urandom); wide_sel = 1'($urandom);
        par_en = 1'($urandom); par_odd = 1'($urandom);
        chk("R2", "busy after load", busy, 1);
        chk("R2", "start bit", txd, 0);
        for (int b = 0; b < nb; b++) begin
            for (int t = 0; t < 16; t++) begin
                if (t == 0) begin
                    cap[b] = txd;
                    chk(tag, $sformatf("bit %0d", b), txd, ef[b]);
                end
                if (t == 15) chk("R3", $sformatf("hold bit %0d", b), txd, ef[b]);
                if (t > 0) chk("R10", "no early done", done, 0);
                if (inject && b == 3 && t == 5) begin
                    load = 1'b1;
                    data_in = ~d; wide_sel = ~w; par_en = ~pe;
                end
                one_tick(b != nb - 1 || t != 15);
                load = 1'b0;
            end
        end
        chk("R10", "done pulse", done, 1);
        chk("R10", "busy falls", busy, 0);
        chk("R1", "line high after frame", txd, 1);
        @(negedge clk);
        chk("R10", "done one cycle", done, 0);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset txd", txd, 1);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        for (int i = 0; i < 20; i++) one_tick(1'b1);
        chk("R1", "idle with ticks txd", txd, 1);
        chk("R1", "idle with ticks busy", busy, 0);

        send_frame(9'h035, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8", "0x35 even parity bit", cap[8], 0);
        send_frame(9'h035, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8", "0x35 odd parity bit", cap[8], 1);
        send_frame(9'h0B5, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5", "msb overwritten by even parity", cap[8], 0);
        send_frame(9'h1FF, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R7", "msb overwritten wide", cap[9], 0);
        send_frame(9'h1A5, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6", "ninth data bit", cap[9], 1);
        send_frame(9'h155, 1'b0, 1'b0, 1'b0, 1'b1);

        for (int k = 0; k < 40; k++) begin
            send_frame(9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                       ($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule